// File: doc/BRIEF.md
# UART Command Register Bridge

This block turns a stream of bytes from a serial receiver into register accesses for a counter-mode block-cipher engine. Each byte received while the bridge is idle is taken as a command. The upper nibble of a command selects a register, and bit 0 marks it as a write. A write command takes the next received byte as its data. A read command sends one reply byte back to the serial transmitter on the following clock cycle.

The wide cipher operands are loaded through one address each. The 128-bit key, the 96-bit nonce and the 128-bit input block are each filled by repeated byte writes to their own address. The 128-bit result is drained the same way, through repeated reads of one address. A small control register drives the engine's clear and counter-mode lines and issues a one-cycle start pulse. A status byte reports whether a result is waiting to be read.

The cipher engine sits outside the block. It returns its result on a valid strobe. The serial bit-level logic also sits outside, and the block sees it as byte-wide valid interfaces.

Top module: `uart_reg_bridge`

## Requirements
- R1: After reset, tx_valid_o, crypt_start_o, eng_clear_o and ctr_mode_o are 0, key_o, nonce_o and din_o are all zero, and a status read returns 0x00.
- R2: Command 0x00 makes tx_valid_o high for one cycle, in the cycle after the command byte. tx_byte_o then carries the status: bit 0 is clear, bit 1 is counter mode, bit 2 is the start pulse, bit 3 is result valid, and bits 7:4 are 0.
- R3: Command 0x01 followed by a data byte loads control bit 0 into eng_clear_o and control bit 1 into ctr_mode_o. Both hold until the next control write.
- R4: Commands 0x11, 0x21 and 0x31 each write their following data byte into the key (16 bytes), the nonce (12 bytes) or the input block (16 bytes). The first byte after a pointer reset lands in bits [W-1:W-8], and each later byte goes 8 bits lower.
- R5: Each wide register has its own byte pointer. After the last byte position the pointer wraps, so the next write lands in the most significant byte again.
- R6: A control write with bit 0 set returns all three write pointers and the result read pointer to the first position, and clears the result-valid flag. It leaves the register contents unchanged.
- R7: A control write with bit 2 set drives crypt_start_o high for exactly one cycle. Bit 2 is not stored, so later status reads show bit 2 as 0.
- R8: A cycle with core_res_valid_i high captures core_res_i and sets status bit 3.
- R9: Command 0x40 returns one byte of the captured result per command, most significant byte first, over 16 commands.
- R10: The result-valid flag clears when the 16th result byte is read, or when a control write requests a new start.
- R11: A command byte outside {0x00, 0x01, 0x11, 0x21, 0x31, 0x40} produces no reply and changes no register. The byte after it is decoded as a new command.
- R12: tx_valid_o rises only in the cycle after a read command. A data byte following a write command never produces a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Reply byte strobe |
| tx_byte_o | output | 8 | Reply byte |
| key_o | output | 128 | Assembled key |
| nonce_o | output | 96 | Assembled nonce |
| din_o | output | 128 | Assembled input block |
| eng_clear_o | output | 1 | Engine clear level (control bit 0) |
| ctr_mode_o | output | 1 | Counter mode enable (control bit 1) |
| crypt_start_o | output | 1 | One-cycle start pulse to the engine |
| core_res_valid_i | input | 1 | Engine result strobe |
| core_res_i | input | 128 | Engine result block |

## Verification
The hardest states to reach from the ports are those where a pointer and the valid flag are not in their usual positions. Examples are a partly written key at the moment a clearing control write arrives, and a pending result that a new start request throws away before it is read. The bench reaches these with directed sequences. It stops a key load after three bytes, then clears. It issues a start while a result is waiting and polls status before the engine stub answers, because the stub replies about twenty cycles late. Random full load, start, poll and drain rounds, with random idle gaps between bytes, then exercise pointer wrap and byte order across rounds.

// File: rtl/urb_pkg.sv
package urb_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_RD_STAT  = 8'h00;
  localparam logic [7:0] CMD_WR_CTRL  = 8'h01;
  localparam logic [7:0] CMD_WR_KEY   = 8'h11;
  localparam logic [7:0] CMD_WR_NONCE = 8'h21;
  localparam logic [7:0] CMD_WR_DIN   = 8'h31;
  localparam logic [7:0] CMD_RD_OUT   = 8'h40;

  localparam int CTL_CLR   = 0;
  localparam int CTL_CTR   = 1;
  localparam int CTL_CRYPT = 2;

  typedef enum logic [1:0] {TGT_CTRL, TGT_KEY, TGT_NONCE, TGT_DIN} tgt_e;
endpackage

// File: rtl/urb_wide_reg.sv
module urb_wide_reg #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [BYTE_W-1:0]        byte_i,
  output logic [NBYTES*BYTE_W-1:0] data_o
);
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  logic [NBYTES-1:0][BYTE_W-1:0] mem_q;
  logic [PW-1:0]                 ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else if (wr_i) begin
      mem_q[LAST - ptr_q] <= byte_i;
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
    end
  end

  assign data_o = mem_q;

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST); // R5
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && ptr_q == LAST) |=> (ptr_q == '0)); // R5
  AST_PTR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0)); // R6
endmodule

// File: rtl/urb_out_drain.sv
module urb_out_drain #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [NBYTES*BYTE_W-1:0] load_data_i,
  input  logic                     cancel_i,
  input  logic                     rd_i,
  output logic [BYTE_W-1:0]        byte_o,
  output logic                     valid_o
);
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  logic [NBYTES-1:0][BYTE_W-1:0] blk_q;
  logic [PW-1:0]                 ptr_q;
  logic                          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      blk_q   <= load_data_i;
      ptr_q   <= '0;
      valid_q <= 1'b1;
    end else begin
      if (cancel_i) valid_q <= 1'b0;
      if (rd_i) begin
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
        if (ptr_q == LAST) valid_q <= 1'b0;
      end
    end
  end

  assign byte_o  = blk_q[LAST - ptr_q];
  assign valid_o = valid_q;

  AST_LOAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> valid_o); // R8
  AST_DRAIN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ptr_q == LAST && !load_i && !clr_i) |=> !valid_o); // R10
  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !load_i) |=> !valid_o); // R10
  AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!valid_o && ptr_q == '0)); // R6
endmodule

// File: rtl/urb_cmd_dec.sv
module urb_cmd_dec
  import urb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       out_valid_i,
  input  logic [7:0] out_byte_i,
  output logic       wr_key_o,
  output logic       wr_nonce_o,
  output logic       wr_din_o,
  output logic [7:0] wr_byte_o,
  output logic       rd_out_o,
  output logic       clr_o,
  output logic       crypt_req_o,
  output logic       eng_clear_o,
  output logic       ctr_mode_o,
  output logic       crypt_start_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o
);
  logic       wait_data_q;
  tgt_e       tgt_q, tgt_d;
  logic [1:0] ctrl_q;
  logic       start_q;
  logic       tx_valid_q;
  logic [7:0] tx_byte_q;

  logic cmd_fire, data_fire, is_rd_stat, is_wr, ctrl_wr;
  logic [7:0] status;

  always_comb begin
    cmd_fire   = rx_valid_i && !wait_data_q;
    data_fire  = rx_valid_i && wait_data_q;
    is_rd_stat = cmd_fire && (rx_byte_i == CMD_RD_STAT);
    rd_out_o   = cmd_fire && (rx_byte_i == CMD_RD_OUT);
    is_wr      = 1'b1;
    tgt_d      = TGT_CTRL;
    case (rx_byte_i)
      CMD_WR_CTRL:  tgt_d = TGT_CTRL;
      CMD_WR_KEY:   tgt_d = TGT_KEY;
      CMD_WR_NONCE: tgt_d = TGT_NONCE;
      CMD_WR_DIN:   tgt_d = TGT_DIN;
      default:      is_wr = 1'b0;
    endcase
    is_wr       = is_wr && cmd_fire;
    ctrl_wr     = data_fire && (tgt_q == TGT_CTRL);
    wr_key_o    = data_fire && (tgt_q == TGT_KEY);
    wr_nonce_o  = data_fire && (tgt_q == TGT_NONCE);
    wr_din_o    = data_fire && (tgt_q == TGT_DIN);
    wr_byte_o   = rx_byte_i;
    clr_o       = ctrl_wr && rx_byte_i[CTL_CLR];
    crypt_req_o = ctrl_wr && rx_byte_i[CTL_CRYPT];
    status      = {4'b0000, out_valid_i, start_q, ctrl_q[CTL_CTR], ctrl_q[CTL_CLR]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_data_q <= 1'b0;
      tgt_q       <= TGT_CTRL;
      ctrl_q      <= '0;
      start_q     <= 1'b0;
      tx_valid_q  <= 1'b0;
      tx_byte_q   <= '0;
    end else begin
      if (is_wr) begin
        wait_data_q <= 1'b1;
        tgt_q       <= tgt_d;
      end else if (data_fire) begin
        wait_data_q <= 1'b0;
      end
      if (ctrl_wr) ctrl_q <= rx_byte_i[1:0];
      start_q    <= crypt_req_o;
      tx_valid_q <= is_rd_stat || rd_out_o;
      if (is_rd_stat)    tx_byte_q <= status;
      else if (rd_out_o) tx_byte_q <= out_byte_i;
    end
  end

  assign eng_clear_o   = ctrl_q[CTL_CLR];
  assign ctr_mode_o    = ctrl_q[CTL_CTR];
  assign crypt_start_o = start_q;
  assign tx_valid_o    = tx_valid_q;
  assign tx_byte_o     = tx_byte_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crypt_start_o |=> !crypt_start_o); // R7
  AST_TX_AFTER_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(rx_valid_i)); // R12
  AST_NO_TX_ON_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fire |=> !tx_valid_o); // R12
  AST_ONE_HOT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_key_o, wr_nonce_o, wr_din_o, ctrl_wr})); // R4
endmodule

// File: rtl/uart_reg_bridge.sv
module uart_reg_bridge #(
  parameter int KEY_BYTES   = 16,
  parameter int NONCE_BYTES = 12,
  parameter int BLK_BYTES   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_byte_i,
  output logic                     tx_valid_o,
  output logic [7:0]               tx_byte_o,
  output logic [KEY_BYTES*8-1:0]   key_o,
  output logic [NONCE_BYTES*8-1:0] nonce_o,
  output logic [BLK_BYTES*8-1:0]   din_o,
  output logic                     eng_clear_o,
  output logic                     ctr_mode_o,
  output logic                     crypt_start_o,
  input  logic                     core_res_valid_i,
  input  logic [BLK_BYTES*8-1:0]   core_res_i
);
  logic       wr_key, wr_nonce, wr_din, rd_out, clr, crypt_req, out_valid;
  logic [7:0] wr_byte, out_byte;

  urb_cmd_dec i_dec (
    .clk_i, .rst_ni, .rx_valid_i, .rx_byte_i,
    .out_valid_i (out_valid),
    .out_byte_i  (out_byte),
    .wr_key_o    (wr_key),
    .wr_nonce_o  (wr_nonce),
    .wr_din_o    (wr_din),
    .wr_byte_o   (wr_byte),
    .rd_out_o    (rd_out),
    .clr_o       (clr),
    .crypt_req_o (crypt_req),
    .eng_clear_o, .ctr_mode_o, .crypt_start_o, .tx_valid_o, .tx_byte_o
  );

  urb_wide_reg #(.NBYTES(KEY_BYTES), .BYTE_W(8)) i_key (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_key), .byte_i(wr_byte), .data_o(key_o));

  urb_wide_reg #(.NBYTES(NONCE_BYTES), .BYTE_W(8)) i_nonce (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_nonce), .byte_i(wr_byte), .data_o(nonce_o));

  urb_wide_reg #(.NBYTES(BLK_BYTES), .BYTE_W(8)) i_din (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_din), .byte_i(wr_byte), .data_o(din_o));

  urb_out_drain #(.NBYTES(BLK_BYTES), .BYTE_W(8)) i_out (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .load_i      (core_res_valid_i),
    .load_data_i (core_res_i),
    .cancel_i    (crypt_req),
    .rd_i        (rd_out),
    .byte_o      (out_byte),
    .valid_o     (out_valid)
  );
endmodule

// File: tb/test_uart_reg_bridge.sv
module test_uart_reg_bridge;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = '0;
  logic         tx_valid;
  logic [7:0]   tx_byte;
  logic [127:0] key;
  logic [95:0]  nonce;
  logic [127:0] din;
  logic         eng_clear, ctr_mode, crypt_start;
  logic         res_valid = 1'b0;
  logic [127:0] res_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_reg_bridge i_uart_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .key_o(key), .nonce_o(nonce),
    .din_o(din), .eng_clear_o(eng_clear), .ctr_mode_o(ctr_mode),
    .crypt_start_o(crypt_start), .core_res_valid_i(res_valid), .core_res_i(res_data));

  function automatic logic [127:0] engine_model(logic [127:0] k, logic [95:0] n,
                                                logic [127:0] d, logic [31:0] c);
    return k ^ d ^ {n, c} ^ {d[63:0], d[127:64]};
  endfunction

  function automatic logic [7:0] status_of(logic v, logic ctr, logic clr);
    return {4'b0000, v, 1'b0, ctr, clr};
  endfunction

  function automatic logic [7:0] byte_at(logic [127:0] blk, int idx);
    return blk[8*(15-idx) +: 8];
  endfunction

  // engine stub: answers about 20 cycles after a start
  logic [31:0] stub_ctr = '0;
  int          stub_wait = 0;
  int          start_hi = 0;
  always @(posedge clk) begin
    res_valid <= 1'b0;
    if (crypt_start) begin
      start_hi  <= start_hi + 1;
      stub_wait <= 20;
      res_data  <= engine_model(key, nonce, din, stub_ctr);
      stub_ctr  <= stub_ctr + 1;
    end else if (stub_wait > 0) begin
      stub_wait <= stub_wait - 1;
      if (stub_wait == 1) res_valid <= 1'b1;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic       last_v;
  logic [7:0] last_b;

  logic [127:0] e_key = '0, e_din = '0, e_res = '0;
  logic [95:0]  e_nonce = '0;
  int kp = 0, np = 0, dp = 0;
  logic [31:0] e_ctr = '0;
  logic e_ctrm = 0, e_clr = 0;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    last_v = tx_valid;
    last_b = tx_byte;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] cmd, output logic [7:0] b, output logic v);
    put(cmd);
    b = last_b;
    v = last_v;
  endtask

  task automatic wide_wr(logic [7:0] cmd, logic [7:0] b);
    put(cmd);
    put(b);
    case (cmd)
      8'h11: begin e_key[8*(15-kp) +: 8] = b; kp = (kp + 1) % 16; end
      8'h21: begin e_nonce[8*(11-np) +: 8] = b; np = (np + 1) % 12; end
      default: begin e_din[8*(15-dp) +: 8] = b; dp = (dp + 1) % 16; end
    endcase
  endtask

  task automatic ctrl_wr(logic [7:0] b);
    put(8'h01);
    put(b);
    e_clr  = b[0];
    e_ctrm = b[1];
    if (b[0]) begin kp = 0; np = 0; dp = 0; end
    if (b[2]) begin
      e_res = engine_model(e_key, e_nonce, e_din, e_ctr);
      e_ctr++;
    end
  endtask

  task automatic poll_valid(string req);
    logic [7:0] s; logic v; bit seen;
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      rd(8'h00, s, v);
      if (v && s[3]) seen = 1;
    end
    check(req, 128'(seen), 128'd1);
  endtask

  task automatic drain(string req);
    logic [7:0] b; logic v;
    for (int i = 0; i < 16; i++) begin
      rd(8'h40, b, v);
      check(req, {119'd0, v, b}, {119'd0, 1'b1, byte_at(e_res, i)});
    end
  endtask

  initial begin
    logic [7:0] s; logic v; int hi0; logic [127:0] key_snap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", 128'(tx_valid), 0);
    check("R1 regs", key ^ din ^ {nonce, 32'd0}, 0);
    check("R1 ctrl outs", {125'd0, eng_clear, ctr_mode, crypt_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, s, v);
    check("R1 R2 status after reset", {v, s}, {1'b1, 8'h00});

    // R3 control write
    ctrl_wr(8'h02);
    check("R3 ctr_mode", {eng_clear, ctr_mode}, 2'b01);
    rd(8'h00, s, v);
    check("R2 R3 status", {v, s}, {1'b1, status_of(0, 1, 0)});

    // R4 key/nonce/din loads, R12 no reply on data
    for (int i = 0; i < 16; i++) wide_wr(8'h11, 8'($urandom));
    check("R12 no reply on data byte", 128'(last_v), 0);
    for (int i = 0; i < 12; i++) wide_wr(8'h21, 8'($urandom));
    for (int i = 0; i < 16; i++) wide_wr(8'h31, 8'(i * 17 + 3));
    check("R4 key", key, e_key);
    check("R4 nonce", {32'd0, nonce}, {32'd0, e_nonce});
    check("R4 din", din, e_din);

    // R5 wrap: 17th byte goes to MSB
    wide_wr(8'h11, 8'hA5);
    check("R5 key wrap", key, e_key);
    check("R5 key msb", 128'(key[127:120]), 128'hA5);

    // R7 start pulse, R8 valid, R9 drain, R10 clear after 16th
    hi0 = start_hi;
    ctrl_wr(8'h06);
    repeat (2) @(negedge clk);
    check("R7 single start pulse", 128'(start_hi - hi0), 1);
    rd(8'h00, s, v);
    check("R7 bit2 not stored", 128'(s[2:1]), 128'b01);
    poll_valid("R8 valid flag");
    drain("R9 out byte");
    rd(8'h00, s, v);
    check("R10 valid cleared after drain", 128'(s[3]), 0);

    // R10 cancel by new start
    ctrl_wr(8'h06);
    poll_valid("R8 valid again");
    ctrl_wr(8'h06);
    rd(8'h00, s, v);
    check("R10 cancel on start", 128'(s[3]), 0);
    poll_valid("R8 valid after cancel");
    drain("R9 out after cancel");

    // R6 clear mid-load
    ctrl_wr(8'h06);
    poll_valid("R8 before clear");
    for (int i = 0; i < 3; i++) wide_wr(8'h11, 8'($urandom));
    key_snap = e_key;
    ctrl_wr(8'h01);
    check("R6 eng_clear level", {eng_clear, ctr_mode}, 2'b10);
    check("R6 contents kept", key, key_snap);
    rd(8'h00, s, v);
    check("R6 status valid cleared", {v, s}, {1'b1, status_of(0, 0, 1)});
    wide_wr(8'h11, 8'h3C);
    check("R6 key ptr reset", 128'(key[127:120]), 128'h3C);
    ctrl_wr(8'h02);

    // R11 unsupported commands
    key_snap = key;
    put(8'h30); check("R11 no reply 0x30", 128'(last_v), 0);
    put(8'h41); check("R11 no reply 0x41", 128'(last_v), 0);
    put(8'hFF); check("R11 no reply 0xFF", 128'(last_v), 0);
    put(8'h10); check("R11 no reply 0x10", 128'(last_v), 0);
    rd(8'h00, s, v);
    check("R11 next byte is command", {v, s}, {1'b1, status_of(0, 1, 0)});
    check("R11 key unchanged", key, key_snap);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      ctrl_wr(8'h01);
      ctrl_wr(8'h02);
      for (int i = 0; i < 16; i++) wide_wr(8'h11, 8'($urandom));
      for (int i = 0; i < 12; i++) wide_wr(8'h21, 8'($urandom));
      for (int i = 0; i < 16; i++) wide_wr(8'h31, 8'($urandom));
      check("R4 random key", key, e_key);
      check("R4 random din", din, e_din);
      ctrl_wr(8'h06);
      poll_valid("R8 random");
      drain("R9 random");
      rd(8'h00, s, v);
      check("R10 random cleared", 128'(s[3]), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule